// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 16-bit operand address for an 8-bit processor whose addressing model is built around indexing. One request is accepted per operation. Each request carries a compact mode descriptor plus the current register values. The block picks a base from X, Y, U, S or the program counter and adds a signed offset to it. The offset is a 5-, 8- or 16-bit constant, the A or B accumulator, or the 16-bit A:B pair. The block also supports auto-increment and auto-decrement of the base, the page-register/operand concatenation and plain 16-bit absolute addresses.

Any indexed or absolute address may be made indirect. In that case the block reads a 16-bit pointer through its memory read port, high byte first, and the pointer becomes the final address. For address-load operations the final address is offered as a write into X, Y, U or S. Only the X and Y targets carry a zero-flag update. The instruction sequencer that owns the register file applies the write-back pulses. That sequencer waits on `busy_o` and takes the result when `done_o` is high.

Top module: `idx_ea_gen`

## Requirements
- R1: While reset is asserted and after it is released with no request, busy_o, done_o, err_o, mem_rd_o, base_we_o, lea_we_o and z_we_o are 0, and ea_o is 0.
- R2: Kind codes 0 (no offset), 1 (5-bit constant ofs_i[4:0]), 2 (8-bit constant ofs_i[7:0]) and 3 (16-bit ofs_i) add the sign-extended constant to the base. The base is selected by base_sel_i: 0=X, 1=Y, 2=U, 3=S, 4=PC.
- R3: Kind 4 adds sign-extended a_i, kind 5 adds sign-extended b_i, and kind 6 adds {a_i,b_i} to the base.
- R4: Kinds 7 and 8 use the base as the address and write base+1 and base+2 respectively back to the base register. Kinds 9 and 10 subtract 1 and 2 respectively and use the decremented value as both the address and the write-back. The write-back is one pulse of base_we_o in the done cycle, with base_sel_o equal to the request's base_sel_i, even when indirection follows.
- R5: With base_sel_i=4 the offset is added to pc_i, which is the address of the byte after the instruction.
- R6: Kind 11 forms {dp_i, ofs_i[7:0]}. Kind 12 uses ofs_i directly. Neither reads a base register.
- R7: With indirect_i set, the block reads two bytes in the two cycles that follow acceptance: the high byte at the computed address, then the low byte at that address plus 1. mem_rd_o and busy_o are high during both reads. In the next cycle done_o rises with ea_o equal to the pointer.
- R8: Without indirection, done_o is high for exactly one cycle, in the cycle after start_i is accepted, and busy_o stays low.
- R9: With lea_i set, lea_we_o pulses with done_o and lea_sel_o is lea_dst_i (0=X, 1=Y, 2=U, 3=S). For X and Y, z_we_o is 1 and z_o equals (ea_o==0). For U and S, z_we_o stays 0.
- R10: Illegal descriptors raise err_o with done_o, force ea_o to 0, and produce no reads and no base or address-load write. The illegal cases are: kind 13 to 15; base_sel_i above 4 on kinds 0 to 10; PC base with kinds 7 to 10; indirection on kind 11; address load on kinds 11 or 12.
- R11: All address, offset, step and pointer-byte arithmetic wraps modulo 2^16.
- R12: start_i is ignored while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, accepted when idle |
| kind_i | input | 4 | Offset/mode kind code |
| base_sel_i | input | 3 | Base register select |
| indirect_i | input | 1 | Fetch pointer at computed address |
| lea_i | input | 1 | Address-load operation |
| lea_dst_i | input | 2 | Address-load target register |
| x_i | input | 16 | X register |
| y_i | input | 16 | Y register |
| u_i | input | 16 | U register |
| s_i | input | 16 | S register |
| pc_i | input | 16 | Address of byte after instruction |
| a_i | input | 8 | Accumulator A |
| b_i | input | 8 | Accumulator B |
| dp_i | input | 8 | Page register |
| ofs_i | input | 16 | Offset or operand bytes |
| mem_rd_o | output | 1 | Pointer read strobe |
| mem_addr_o | output | 16 | Pointer read address |
| mem_data_i | input | 8 | Read data, same cycle |
| busy_o | output | 1 | Pointer fetch in progress |
| done_o | output | 1 | Result valid |
| err_o | output | 1 | Illegal descriptor |
| ea_o | output | 16 | Final effective address |
| base_we_o | output | 1 | Base register write-back strobe |
| base_sel_o | output | 3 | Base register to write |
| base_val_o | output | 16 | Updated base value |
| lea_we_o | output | 1 | Address-load write strobe |
| lea_sel_o | output | 2 | Address-load target |
| z_we_o | output | 1 | Zero flag write strobe |
| z_o | output | 1 | Zero flag value |

## Verification
The bench builds the block at its default data width of 8, which gives a 16-bit address space. With that width, a 5-bit offset of -16, an 8-bit offset of 0x80 and accumulator values with the top bit set all exercise negative sign extension. Registers near 0x0000 and 0xFFFF make the auto-step and pointer-fetch arithmetic wrap. The memory model returns a byte computed from the address, so the pointer value shows which byte came from which address and in what order.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam logic [3:0] K_ZERO   = 4'd0;
  localparam logic [3:0] K_C5     = 4'd1;
  localparam logic [3:0] K_C8     = 4'd2;
  localparam logic [3:0] K_C16    = 4'd3;
  localparam logic [3:0] K_ACC_A  = 4'd4;
  localparam logic [3:0] K_ACC_B  = 4'd5;
  localparam logic [3:0] K_ACC_D  = 4'd6;
  localparam logic [3:0] K_POST1  = 4'd7;
  localparam logic [3:0] K_POST2  = 4'd8;
  localparam logic [3:0] K_PRE1   = 4'd9;
  localparam logic [3:0] K_PRE2   = 4'd10;
  localparam logic [3:0] K_DIRECT = 4'd11;
  localparam logic [3:0] K_ABS    = 4'd12;

  localparam logic [2:0] BS_X  = 3'd0;
  localparam logic [2:0] BS_Y  = 3'd1;
  localparam logic [2:0] BS_U  = 3'd2;
  localparam logic [2:0] BS_S  = 3'd3;
  localparam logic [2:0] BS_PC = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_RD_HI, ST_RD_LO, ST_FIN} ea_state_e;
endpackage

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_ea_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 5,
  localparam int AW = 2 * DW
) (
  input  logic [3:0]    kind_i,
  input  logic [2:0]    base_sel_i,
  input  logic          indirect_i,
  input  logic          lea_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  input  logic [AW-1:0] u_i,
  input  logic [AW-1:0] s_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] dp_i,
  input  logic [AW-1:0] ofs_i,
  output logic [AW-1:0] addr_o,
  output logic          nb_we_o,
  output logic [AW-1:0] nb_val_o,
  output logic          illegal_o
);
  logic [AW-1:0] base, step;
  logic          uses_base, auto_m, abs_m;

  always_comb begin
    case (base_sel_i)
      BS_X:    base = x_i;
      BS_Y:    base = y_i;
      BS_U:    base = u_i;
      BS_S:    base = s_i;
      BS_PC:   base = pc_i;
      default: base = '0;
    endcase
    uses_base = (kind_i <= K_PRE2);
    auto_m    = (kind_i >= K_POST1) && (kind_i <= K_PRE2);
    abs_m     = (kind_i == K_DIRECT) || (kind_i == K_ABS);
    step      = (kind_i == K_POST2 || kind_i == K_PRE2) ? AW'(2) : AW'(1);
    nb_val_o  = base;
    case (kind_i)
      K_C5:             addr_o = base + {{(AW-SW){ofs_i[SW-1]}}, ofs_i[SW-1:0]};
      K_C8:             addr_o = base + {{(AW-DW){ofs_i[DW-1]}}, ofs_i[DW-1:0]};
      K_C16:            addr_o = base + ofs_i;
      K_ACC_A:          addr_o = base + {{(AW-DW){a_i[DW-1]}}, a_i};
      K_ACC_B:          addr_o = base + {{(AW-DW){b_i[DW-1]}}, b_i};
      K_ACC_D:          addr_o = base + {a_i, b_i};
      K_POST1, K_POST2: begin
        addr_o   = base;
        nb_val_o = base + step;
      end
      K_PRE1, K_PRE2: begin
        addr_o   = base - step;
        nb_val_o = base - step;
      end
      K_DIRECT:         addr_o = {dp_i, ofs_i[DW-1:0]};
      K_ABS:            addr_o = ofs_i;
      default:          addr_o = base;
    endcase
    nb_we_o   = auto_m;
    illegal_o = (kind_i > K_ABS)
              || (uses_base && base_sel_i > BS_PC)
              || (auto_m && base_sel_i == BS_PC)
              || (kind_i == K_DIRECT && indirect_i)
              || (lea_i && abs_m);
  end
endmodule

// File: rtl/idx_lea_ctl.sv
module idx_lea_ctl #(
  parameter int AW = 16
) (
  input  logic          fin_i,
  input  logic          lea_i,
  input  logic          err_i,
  input  logic [1:0]    dst_i,
  input  logic [AW-1:0] ea_i,
  output logic          lea_we_o,
  output logic [1:0]    lea_sel_o,
  output logic          z_we_o,
  output logic          z_o
);
  always_comb begin
    lea_we_o  = fin_i && lea_i && !err_i;
    lea_sel_o = dst_i;
    // only the two index targets (codes 0,1) touch the flag
    z_we_o    = lea_we_o && !dst_i[1];
    z_o       = z_we_o && (ea_i == '0);
  end
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    kind_i,
  input  logic [2:0]    base_sel_i,
  input  logic          indirect_i,
  input  logic          lea_i,
  input  logic [1:0]    lea_dst_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  input  logic [AW-1:0] u_i,
  input  logic [AW-1:0] s_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] dp_i,
  input  logic [AW-1:0] ofs_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] ea_o,
  output logic          base_we_o,
  output logic [2:0]    base_sel_o,
  output logic [AW-1:0] base_val_o,
  output logic          lea_we_o,
  output logic [1:0]    lea_sel_o,
  output logic          z_we_o,
  output logic          z_o
);
  ea_state_e     state_q;
  logic [AW-1:0] ea_q, nb_val_q, calc_addr, calc_nb;
  logic [DW-1:0] hi_q;
  logic          err_q, lea_q, nb_we_q, calc_nb_we, calc_ill;
  logic [1:0]    dst_q;
  logic [2:0]    bsel_q;
  logic          fin;

  idx_ea_calc #(.DW(DW)) calc_i (
    .kind_i, .base_sel_i, .indirect_i, .lea_i,
    .x_i, .y_i, .u_i, .s_i, .pc_i, .a_i, .b_i, .dp_i, .ofs_i,
    .addr_o(calc_addr), .nb_we_o(calc_nb_we), .nb_val_o(calc_nb),
    .illegal_o(calc_ill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ea_q     <= '0;
      nb_val_q <= '0;
      hi_q     <= '0;
      err_q    <= 1'b0;
      lea_q    <= 1'b0;
      nb_we_q  <= 1'b0;
      dst_q    <= '0;
      bsel_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          ea_q     <= calc_addr;
          nb_val_q <= calc_nb;
          nb_we_q  <= calc_nb_we;
          err_q    <= calc_ill;
          lea_q    <= lea_i;
          dst_q    <= lea_dst_i;
          bsel_q   <= base_sel_i;
          state_q  <= (indirect_i && !calc_ill) ? ST_RD_HI : ST_FIN;
        end
        ST_RD_HI: begin
          hi_q    <= mem_data_i;
          state_q <= ST_RD_LO;
        end
        ST_RD_LO: begin
          ea_q    <= {hi_q, mem_data_i};
          state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    fin        = (state_q == ST_FIN);
    busy_o     = (state_q == ST_RD_HI) || (state_q == ST_RD_LO);
    mem_rd_o   = busy_o;
    mem_addr_o = (state_q == ST_RD_LO) ? ea_q + AW'(1) : ea_q;
    done_o     = fin;
    err_o      = fin && err_q;
    ea_o       = (fin && !err_q) ? ea_q : '0;
    base_we_o  = fin && nb_we_q && !err_q;
    base_sel_o = bsel_q;
    base_val_o = nb_val_q;
  end

  idx_lea_ctl #(.AW(AW)) lea_i_u (
    .fin_i(fin), .lea_i(lea_q), .err_i(err_q), .dst_i(dst_q), .ea_i(ea_o),
    .lea_we_o, .lea_sel_o, .z_we_o, .z_o
  );

  // R7
  rd_only_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy_o && !done_o);
  // R7
  lo_after_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && $past(mem_rd_o)) |-> mem_addr_o == $past(mem_addr_o) + AW'(1));
  // R10
  err_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !base_we_o && !lea_we_o && !z_we_o);
  // R4
  wb_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_o |=> !base_we_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  // R12
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R9
  zflag_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_we_o |-> lea_we_o && done_o && !lea_sel_o[1]);
endmodule

// File: tb/idx_ea_gen_tb_top.sv
module idx_ea_gen_tb_top;
  logic        clk_i = 0, rst_ni = 0, start_i = 0;
  logic [3:0]  kind_i = 0;
  logic [2:0]  base_sel_i = 0;
  logic        indirect_i = 0, lea_i = 0;
  logic [1:0]  lea_dst_i = 0;
  logic [15:0] x_i = 0, y_i = 0, u_i = 0, s_i = 0, pc_i = 0, ofs_i = 0;
  logic [7:0]  a_i = 0, b_i = 0, dp_i = 0, mem_data_i;
  logic        mem_rd_o, busy_o, done_o, err_o, base_we_o, lea_we_o, z_we_o, z_o;
  logic [15:0] mem_addr_o, ea_o, base_val_o;
  logic [2:0]  base_sel_o;
  logic [1:0]  lea_sel_o;
  int vecs = 0, fails = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] memb(logic [15:0] ad);
    return ad[7:0] ^ ad[15:8] ^ 8'h5A;
  endfunction
  assign mem_data_i = memb(mem_addr_o);

  idx_ea_gen dut_i (.*);

  task automatic chk(string req, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h exp %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(string req);
    chk(req, "busy", busy_o, 0);
    chk(req, "done", done_o, 0);
    chk(req, "rd", mem_rd_o, 0);
    chk(req, "err", err_o, 0);
    chk(req, "base_we", base_we_o, 0);
    chk(req, "lea_we", lea_we_o, 0);
    chk(req, "z_we", z_we_o, 0);
    chk(req, "ea", ea_o, 0);
  endtask

  function automatic int sx(int v, int bits);
    return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
  endfunction

  // reference model; busy_hit drives a second start during the first read
  task automatic go(string req, bit busy_hit = 0);
    int base, ea, nb, ptr;
    bit ub, am, err, bwe, ind;
    case (base_sel_i)
      0: base = x_i; 1: base = y_i; 2: base = u_i; 3: base = s_i; 4: base = pc_i;
      default: base = 0;
    endcase
    ub  = kind_i <= 10;
    am  = kind_i >= 7 && kind_i <= 10;
    err = kind_i > 12 || (ub && base_sel_i > 4) || (am && base_sel_i == 4) ||
          (kind_i == 11 && indirect_i) || (lea_i && kind_i >= 11);
    nb  = base;
    case (kind_i)
      1: ea = base + sx(ofs_i[4:0], 5);
      2: ea = base + sx(ofs_i[7:0], 8);
      3: ea = base + ofs_i;
      4: ea = base + sx(a_i, 8);
      5: ea = base + sx(b_i, 8);
      6: ea = base + a_i * 256 + b_i;
      7, 8: begin ea = base; nb = base + kind_i - 6; end
      9, 10: begin nb = base - (kind_i - 8); ea = nb; end
      11: ea = dp_i * 256 + ofs_i[7:0];
      12: ea = ofs_i;
      default: ea = base;
    endcase
    ea  = ea & 16'hFFFF;
    nb  = nb & 16'hFFFF;
    ind = indirect_i && !err;
    bwe = am && !err;
    @(negedge clk_i);
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    if (ind) begin
      if (busy_hit) begin
        start_i = 1; kind_i = 12; ofs_i = 16'h1111; indirect_i = 0;
      end
      chk(req, "busy_hi", busy_o, 1);
      chk(req, "rd_hi", mem_rd_o, 1);
      chk(req, "done_hi", done_o, 0);
      chk(req, "addr_hi", mem_addr_o, ea);
      @(negedge clk_i);
      start_i = 0;
      chk(req, "busy_lo", busy_o, 1);
      chk(req, "rd_lo", mem_rd_o, 1);
      chk(req, "addr_lo", mem_addr_o, (ea + 1) & 16'hFFFF);
      ptr = memb(16'(ea)) * 256 + memb(16'(ea + 1));
      ea = ptr;
      @(negedge clk_i);
    end else begin
      chk(req, "busy", busy_o, 0);
      chk(req, "rd", mem_rd_o, 0);
    end
    chk(req, "done", done_o, 1);
    chk(req, "err", err_o, err);
    chk(req, "ea", ea_o, err ? 0 : ea);
    chk(req, "base_we", base_we_o, bwe);
    if (bwe) begin
      chk(req, "base_sel", base_sel_o, base_sel_i);
      chk(req, "base_val", base_val_o, nb);
    end
    chk(req, "lea_we", lea_we_o, lea_i && !err);
    if (lea_i && !err) chk(req, "lea_sel", lea_sel_o, lea_dst_i);
    chk(req, "z_we", z_we_o, lea_i && !err && lea_dst_i < 2);
    if (lea_i && !err && lea_dst_i < 2) chk(req, "z", z_o, ea == 0);
    @(negedge clk_i);
    chk_idle(req);
    indirect_i = 0; lea_i = 0;
  endtask

  task automatic op(int k, int bs, logic [15:0] ofs = 0);
    kind_i = 4'(k); base_sel_i = 3'(bs); ofs_i = ofs;
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      report();
    end
  end

  initial begin
    x_i = 16'h1000; y_i = 16'h2000; u_i = 16'h3000; s_i = 16'h4000; pc_i = 16'h8000;
    a_i = 8'hF0; b_i = 8'h7F; dp_i = 8'h12;
    #5 chk_idle("R1");
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk_idle("R1");
    // R2 constants, sign extension
    op(0, 0);          go("R2");
    op(1, 1, 16'h0010); go("R2");
    op(1, 3, 16'h000F); go("R2");
    op(2, 2, 16'h0080); go("R2");
    op(3, 3, 16'h1234); go("R2");
    // R3 accumulators
    op(4, 0); go("R3");
    op(5, 1); go("R3");
    a_i = 8'h12; b_i = 8'h34; op(6, 2); go("R3");
    b_i = 8'h80; op(5, 3); go("R3");
    // R4 auto step
    op(7, 0); go("R4");
    op(8, 2); go("R4");
    op(9, 3); go("R4");
    op(10, 1); go("R4");
    // R5 PC base
    op(2, 4, 16'h00FE); go("R5");
    op(3, 4, 16'h0100); go("R5");
    op(6, 4); go("R5");
    // R6 page and absolute
    op(11, 5, 16'hFFAB); go("R6");
    op(12, 7, 16'h4000); go("R6");
    // R7 indirection
    op(1, 0, 16'h0003); indirect_i = 1; go("R7");
    op(12, 0, 16'h2345); indirect_i = 1; go("R7");
    op(8, 1); indirect_i = 1; go("R7_R4");
    op(9, 4 - 4 + 2); indirect_i = 1; go("R7_R4");
    // R9 address load
    x_i = 16'h0005; op(1, 0, 16'h001B); lea_i = 1; lea_dst_i = 0; go("R9");
    op(2, 1, 16'h0001); lea_i = 1; lea_dst_i = 1; go("R9");
    op(0, 2); lea_i = 1; lea_dst_i = 2; go("R9");
    op(0, 0); lea_i = 1; lea_dst_i = 3; go("R9");
    op(3, 3, 16'h0010); indirect_i = 1; lea_i = 1; lea_dst_i = 1; go("R9");
    // R10 illegal
    op(11, 0, 16'h0044); indirect_i = 1; go("R10");
    op(0, 6); go("R10");
    op(7, 4); go("R10");
    op(14, 0); go("R10");
    op(11, 0); lea_i = 1; lea_dst_i = 0; go("R10");
    op(12, 0, 16'h0100); lea_i = 1; lea_dst_i = 2; go("R10");
    // R11 wrap
    x_i = 16'hFFFF; op(7, 0); go("R11");
    s_i = 16'h0001; op(10, 3); go("R11");
    op(3, 0, 16'h0002); go("R11");
    op(12, 0, 16'hFFFF); indirect_i = 1; go("R11");
    // R12 start while busy ignored
    op(3, 2, 16'h0040); indirect_i = 1; go("R12", 1);
    finished = 1;
    report();
  end
endmodule